// File: doc/BRIEF.md
# Raster Line Interrupt Generator

This block keeps the raster position of a video display processor: it counts master clocks within a scan line and scan lines within a frame. From that position it raises two interrupt requests. A line-interval request comes from a reloading down-counter that steps once per visible line. A frame request comes once per frame, at a fixed cycle offset inside the first blanking line. Each request has a sticky pending flag, and an enable bit masks the request output. Acknowledging the matching interrupt level clears the pending flag.

The frame format (PAL or NTSC line counts) and the line width mode (wide or narrow) are sampled only at the start of line 0. A change made during a frame therefore takes effect at the next frame. A small frame-position state machine tracks the vertical region. It has four states. `FRM_TOP` is line 0. `FRM_PRIME` is line 1. `FRM_ACTIVE` covers line 2 up to the last active line. `FRM_BLANK` covers the blanking lines. All transitions happen on the last clock of a line:
- `FRM_TOP` → `FRM_PRIME`: always.
- `FRM_PRIME` → `FRM_ACTIVE`: always.
- `FRM_ACTIVE` → `FRM_BLANK`: when the line ending is the last active line.
- `FRM_BLANK` → `FRM_TOP`: when the line ending is the last line of the frame.

A 16-bit status word reports the frame-pending flag, the blanking region and the latched frame format. It also passes through three bits supplied by neighbouring logic.

Top module: `raster_irq_gen`

## Requirements
- R1: At the first clock of a line whose number is 0 or 1, or is at or beyond the active line count, the line-interval counter is reloaded from `line_interval_i`. No line-interval request is raised on such a line.
- R2: At the first clock of any other line, a nonzero counter decrements. A zero counter instead sets `hpend_o` and is reloaded. With interval N, the first request comes on line 2+N and then every N+1 lines.
- R3: `vpend_o` sets in the line whose number equals the active line count. It sets at the clock whose in-line offset is `VOFS_WIDE` in wide mode and `VOFS_NARROW` in narrow mode.
- R4: The active line count (`NTSC_ACT`/`PAL_ACT`) and the frame length (`NTSC_LINES`/`PAL_LINES`) follow the latched format bit (1 = PAL). The format and width bits are latched only at the first clock of line 0.
- R5: An acknowledge with `ack_level_i` = 6 clears `vpend_o`, and one with level 4 clears `hpend_o`. Any other level leaves both flags unchanged.
- R6: When a flag's set condition and its acknowledge occur on the same clock, the flag ends up set.
- R7: `hirq_o` equals `hpend_o` masked by `hirq_en_i`, and `virq_o` equals `vpend_o` masked by `virq_en_i`. Both are combinational.
- R8: Status bit 7 shows `vpend_o`. Bit 3 is 1 while the current line is at or beyond the active line count. Bit 0 is the latched format bit.
- R9: Status bit 9 = `fifo_full_i`, bit 8 = `fifo_empty_i`, bit 1 = `dma_busy_i`. All other status bits not named in R8 are 0.
- R10: While `rst_i` (synchronous, active high) is asserted, both flags, both requests and the whole status word (with pass-through inputs at 0) are 0. The first clock after release is the first clock of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_i | input | 1 | synchronous reset, active high |
| pal_mode_i | input | 1 | frame format, 1 = PAL line counts |
| wide_mode_i | input | 1 | line width mode, 1 = wide |
| hirq_en_i | input | 1 | line-interval request enable |
| virq_en_i | input | 1 | frame request enable |
| line_interval_i | input | IW | line-interval reload value |
| ack_valid_i | input | 1 | interrupt acknowledge strobe |
| ack_level_i | input | 3 | acknowledged interrupt level |
| fifo_full_i | input | 1 | pass-through status bit 9 |
| fifo_empty_i | input | 1 | pass-through status bit 8 |
| dma_busy_i | input | 1 | pass-through status bit 1 |
| hpend_o | output | 1 | line-interval pending flag |
| vpend_o | output | 1 | frame pending flag |
| hirq_o | output | 1 | masked line-interval request |
| virq_o | output | 1 | masked frame request |
| status_o | output | 16 | status word |

## Verification
The hardest situation to reach from the ports is the collision of a frame-request set with its own acknowledge. The set happens on exactly one clock of the whole frame. The bench therefore counts clocks from reset release, asserts the level-6 acknowledge two clocks before the computed set clock, and holds it across that clock. The bench also shortens the line and the frame through parameters, so that whole frames and the line-0 latching of a format change mid-frame fit into a short run.

// File: rtl/raster_pkg.sv
package raster_pkg;

    typedef enum logic [1:0] {
        FRM_TOP    = 2'd0,
        FRM_PRIME  = 2'd1,
        FRM_ACTIVE = 2'd2,
        FRM_BLANK  = 2'd3
    } frame_st_t;

    localparam logic [2:0] ACK_LVL_H = 3'd4;
    localparam logic [2:0] ACK_LVL_V = 3'd6;

    localparam int FLAG_H = 0;
    localparam int FLAG_V = 1;
    localparam int NUM_FLAGS = 2;

endpackage

// File: rtl/raster_timebase.sv
module raster_timebase #(
    parameter int LINE_CLKS = 3420,
    parameter int HCW = 12,
    parameter int VW = 9
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [VW-1:0]  total_i,
    output logic [HCW-1:0] h_cyc_o,
    output logic [VW-1:0]  v_line_o,
    output logic           line_start_o,
    output logic           line_end_o
);
    localparam logic [HCW-1:0] H_LAST = HCW'(LINE_CLKS - 1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            h_cyc_o  <= '0;
            v_line_o <= '0;
        end else if (h_cyc_o == H_LAST) begin
            h_cyc_o  <= '0;
            v_line_o <= (v_line_o == total_i - VW'(1)) ? '0 : v_line_o + VW'(1);
        end else begin
            h_cyc_o <= h_cyc_o + HCW'(1);
        end
    end

    assign line_start_o = (h_cyc_o == '0);
    assign line_end_o   = (h_cyc_o == H_LAST);
endmodule

// File: rtl/raster_hcount.sv
module raster_hcount #(
    parameter int IW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          line_start_i,
    input  logic          reload_i,
    input  logic [IW-1:0] interval_i,
    output logic          hit_o
);
    logic [IW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (line_start_i) begin
            if (reload_i || cnt_q == '0)
                cnt_q <= interval_i;
            else
                cnt_q <= cnt_q - IW'(1);
        end
    end

    assign hit_o = line_start_i && !reload_i && (cnt_q == '0);
endmodule

// File: rtl/raster_pend_flag.sv
module raster_pend_flag (
    input  logic clk_i,
    input  logic rst_i,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end
endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
    import raster_pkg::*;
#(
    parameter int LINE_CLKS   = 3420,
    parameter int NTSC_LINES  = 262,
    parameter int PAL_LINES   = 313,
    parameter int NTSC_ACT    = 224,
    parameter int PAL_ACT     = 240,
    parameter int VOFS_WIDE   = 752,
    parameter int VOFS_NARROW = 800,
    parameter int IW          = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          pal_mode_i,
    input  logic          wide_mode_i,
    input  logic          hirq_en_i,
    input  logic          virq_en_i,
    input  logic [IW-1:0] line_interval_i,
    input  logic          ack_valid_i,
    input  logic [2:0]    ack_level_i,
    input  logic          fifo_full_i,
    input  logic          fifo_empty_i,
    input  logic          dma_busy_i,
    output logic          hpend_o,
    output logic          vpend_o,
    output logic          hirq_o,
    output logic          virq_o,
    output logic [15:0]   status_o
);
    localparam int HCW = $clog2(LINE_CLKS);
    localparam int MAXL = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES;
    localparam int VW = $clog2(MAXL + 1);

    frame_st_t      state_q, state_d;
    logic           lat_pal_q, lat_wide_q;
    logic [HCW-1:0] h_cyc;
    logic [VW-1:0]  v_line;
    logic           line_start, line_end;
    logic [VW-1:0]  total_lines, act_lines;
    logic [HCW-1:0] vofs_cur;
    logic           reload_zone, hit, vset;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

    assign total_lines = lat_pal_q ? VW'(PAL_LINES) : VW'(NTSC_LINES);
    assign act_lines   = lat_pal_q ? VW'(PAL_ACT) : VW'(NTSC_ACT);
    assign vofs_cur    = lat_wide_q ? HCW'(VOFS_WIDE) : HCW'(VOFS_NARROW);

    raster_timebase #(.LINE_CLKS(LINE_CLKS), .HCW(HCW), .VW(VW)) u_tb (
        .clk_i(clk_i), .rst_i(rst_i), .total_i(total_lines),
        .h_cyc_o(h_cyc), .v_line_o(v_line),
        .line_start_o(line_start), .line_end_o(line_end)
    );

    raster_hcount #(.IW(IW)) u_hc (
        .clk_i(clk_i), .rst_i(rst_i), .line_start_i(line_start),
        .reload_i(reload_zone), .interval_i(line_interval_i), .hit_o(hit)
    );

    // mode latch at the first clock of line 0
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lat_pal_q  <= 1'b0;
            lat_wide_q <= 1'b0;
        end else if (state_q == FRM_TOP && line_start) begin
            lat_pal_q  <= pal_mode_i;
            lat_wide_q <= wide_mode_i;
        end
    end

    // frame-position state register
    always_ff @(posedge clk_i) begin
        if (rst_i)
            state_q <= FRM_TOP;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (line_end) begin
            unique case (state_q)
                FRM_TOP:    state_d = FRM_PRIME;
                FRM_PRIME:  state_d = FRM_ACTIVE;
                FRM_ACTIVE: if (v_line == act_lines - VW'(1)) state_d = FRM_BLANK;
                FRM_BLANK:  if (v_line == total_lines - VW'(1)) state_d = FRM_TOP;
                default:    state_d = FRM_TOP;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        reload_zone = (state_q != FRM_ACTIVE);
        vset        = (state_q == FRM_BLANK) && (v_line == act_lines) && (h_cyc == vofs_cur);
        flag_set[FLAG_H] = hit;
        flag_set[FLAG_V] = vset;
        flag_clr[FLAG_H] = ack_valid_i && (ack_level_i == ACK_LVL_H);
        flag_clr[FLAG_V] = ack_valid_i && (ack_level_i == ACK_LVL_V);
        hpend_o  = flag_q[FLAG_H];
        vpend_o  = flag_q[FLAG_V];
        hirq_o   = flag_q[FLAG_H] && hirq_en_i;
        virq_o   = flag_q[FLAG_V] && virq_en_i;
        status_o    = '0;
        status_o[9] = fifo_full_i;
        status_o[8] = fifo_empty_i;
        status_o[7] = flag_q[FLAG_V];
        status_o[3] = (state_q == FRM_BLANK);
        status_o[1] = dma_busy_i;
        status_o[0] = lat_pal_q;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        raster_pend_flag u_flag (
            .clk_i(clk_i), .rst_i(rst_i),
            .set_i(flag_set[g]), .clr_i(flag_clr[g]), .q_o(flag_q[g])
        );
    end
endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk #(
    parameter int HCW = 12,
    parameter int VW = 9
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic [HCW-1:0] h_cyc_i,
    input logic [VW-1:0]  v_line_i,
    input logic [HCW-1:0] vofs_i,
    input logic           vset_i,
    input logic           hpend_i,
    input logic           vpend_i,
    input logic           hirq_i,
    input logic           hen_i,
    input logic           virq_i,
    input logic           ven_i,
    input logic           ack_valid_i,
    input logic [2:0]     ack_level_i,
    input logic           pal_bit_i,
    input logic           blank_bit_i
);
    p_hpend_line_start_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hpend_i) |-> (h_cyc_i == HCW'(1)));

    p_vpend_offset_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(vpend_i) |-> ($past(h_cyc_i) == $past(vofs_i)));

    p_pal_latched_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (v_line_i != '0) |=> $stable(pal_bit_i));

    p_vack_clears_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_valid_i && ack_level_i == 3'd6 && !vset_i) |=> !vpend_i);

    p_set_wins_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        vset_i |=> vpend_i);

    p_hirq_gate_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        hirq_i |-> (hen_i && hpend_i));

    p_virq_gate_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        virq_i |-> (ven_i && vpend_i));

    p_blank_edge_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(blank_bit_i) |-> (h_cyc_i == '0));
endmodule

bind raster_irq_gen raster_irq_chk #(.HCW(HCW), .VW(VW)) u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .h_cyc_i(h_cyc), .v_line_i(v_line),
    .vofs_i(vofs_cur), .vset_i(vset), .hpend_i(hpend_o), .vpend_i(vpend_o),
    .hirq_i(hirq_o), .hen_i(hirq_en_i), .virq_i(virq_o), .ven_i(virq_en_i),
    .ack_valid_i(ack_valid_i), .ack_level_i(ack_level_i),
    .pal_bit_i(status_o[0]), .blank_bit_i(status_o[3])
);

// File: tb/test_raster_irq_gen.sv
module test_raster_irq_gen;
    localparam int PERIOD = 10;
    localparam int IW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pal = 0, wide = 0, hie = 0, vie = 0;
    logic [IW-1:0] ival = '0;
    logic ack_v = 0;
    logic [2:0] ack_l = '0;
    logic ffull = 0, fempty = 0, dma = 0;
    logic hpend, vpend, hirq, virq;
    logic [15:0] status;

    int n = 0;
    int total = 0;
    int bad = 0;

    always #(PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) n <= 0;
        else n <= n + 1;
    end

    raster_irq_gen #(
        .LINE_CLKS(64), .NTSC_LINES(20), .PAL_LINES(26),
        .NTSC_ACT(12), .PAL_ACT(16), .VOFS_WIDE(20), .VOFS_NARROW(30), .IW(IW)
    ) i_raster_irq_gen (
        .clk_i(clk), .rst_i(rst), .pal_mode_i(pal), .wide_mode_i(wide),
        .hirq_en_i(hie), .virq_en_i(vie), .line_interval_i(ival),
        .ack_valid_i(ack_v), .ack_level_i(ack_l),
        .fifo_full_i(ffull), .fifo_empty_i(fempty), .dma_busy_i(dma),
        .hpend_o(hpend), .vpend_o(vpend), .hirq_o(hirq), .virq_o(virq),
        .status_o(status)
    );

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, n - 1);
        end
    endtask

    task automatic do_reset(input logic p, input logic w, input logic [IW-1:0] iv);
        @(negedge clk);
        rst = 1'b1; pal = p; wide = w; ival = iv;
        ack_v = 0; hie = 0; vie = 0; ffull = 0; fempty = 0; dma = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // leaves the bench at the negedge that follows clock edge k (edge 0 = first after reset)
    task automatic wait_after(input int k);
        while (n != k + 1) @(negedge clk);
    endtask

    task automatic pulse_ack(input logic [2:0] lvl);
        ack_v = 1'b1; ack_l = lvl;
        @(negedge clk);
        ack_v = 1'b0;
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        rst = 1'b1; pal = 1; wide = 1; hie = 1; vie = 1;
        ffull = 0; fempty = 0; dma = 0;
        repeat (3) @(negedge clk);
        chk(hpend, 0, "R10 hpend in reset");
        chk(vpend, 0, "R10 vpend in reset");
        chk({hirq, virq}, 0, "R10 requests in reset");
        chk(status, 0, "R10 status in reset");
    endtask

    task automatic t_hint_interval2;
        do_reset(0, 0, 8'd2);
        hie = 1;
        wait_after(255); chk(hpend, 0, "R2 hpend before line 4");
        wait_after(256); chk(hpend, 1, "R2 hpend at line 4");
        chk(hirq, 1, "R7 hirq enabled");
        hie = 0; #1; chk(hirq, 0, "R7 hirq masked"); hie = 1;
        pulse_ack(3'd4); chk(hpend, 0, "R5 level 4 ack clears hpend");
        wait_after(447); chk(hpend, 0, "R2 hpend before line 7");
        wait_after(448); chk(hpend, 1, "R2 hpend at line 7");
        pulse_ack(3'd4);
        wait_after(640); chk(hpend, 1, "R2 hpend at line 10");
        pulse_ack(3'd4);
        wait_after(1279); chk(hpend, 0, "R1 no hpend in blanking lines");
        wait_after(1535); chk(hpend, 0, "R1 no hpend before line 4 of frame 2");
        wait_after(1536); chk(hpend, 1, "R1 reload on lines 0,1 then hpend at line 4");
    endtask

    task automatic t_hint_every_line;
        do_reset(0, 0, 8'd0);
        wait_after(127); chk(hpend, 0, "R1 no hpend on line 1");
        wait_after(128); chk(hpend, 1, "R2 interval 0 fires on line 2");
        pulse_ack(3'd4); chk(hpend, 0, "R5 ack level 4");
        wait_after(192); chk(hpend, 1, "R2 interval 0 fires on line 3");
    endtask

    task automatic t_vint_ntsc;
        do_reset(0, 0, 8'd255);
        vie = 1;
        wait_after(0);   chk(status[0], 0, "R8 format bit NTSC");
        wait_after(766); chk(status[3], 0, "R8 blank bit before line 12");
        wait_after(767); chk(status[3], 1, "R8 blank bit at line 12");
        wait_after(797); chk(vpend, 0, "R3 vpend before narrow offset");
        wait_after(798); chk(vpend, 1, "R3 vpend at narrow offset");
        chk(status[7], 1, "R8 status bit 7 follows vpend");
        chk(virq, 1, "R7 virq enabled");
        vie = 0; #1; chk(virq, 0, "R7 virq masked"); vie = 1;
        pulse_ack(3'd5); chk(vpend, 1, "R5 level 5 ignored");
        pulse_ack(3'd4); chk(vpend, 1, "R5 level 4 leaves vpend");
        pulse_ack(3'd6); chk(vpend, 0, "R5 level 6 clears vpend");
        chk(status[7], 0, "R8 status bit 7 cleared");
        wait_after(1279); chk(status[3], 0, "R4 NTSC frame wraps after 20 lines");
    endtask

    task automatic t_vint_pal_wide;
        do_reset(1, 1, 8'd255);
        wait_after(0);    chk(status[0], 1, "R8 format bit PAL");
        wait_after(1022); chk(status[3], 0, "R4 PAL still active at line 15");
        wait_after(1023); chk(status[3], 1, "R4 PAL blank at line 16");
        wait_after(1043); chk(vpend, 0, "R3 vpend before wide offset");
        wait_after(1044); chk(vpend, 1, "R3 vpend at wide offset");
        wait_after(1662); chk(status[3], 1, "R4 PAL blank at line 25");
        wait_after(1663); chk(status[3], 0, "R4 PAL frame wraps after 26 lines");
    endtask

    task automatic t_set_wins;
        do_reset(0, 0, 8'd255);
        wait_after(796);
        ack_v = 1'b1; ack_l = 3'd6;
        wait_after(798); chk(vpend, 1, "R6 set beats level 6 ack");
        ack_v = 1'b0;
        wait_after(799); chk(vpend, 1, "R6 vpend held after collision");
    endtask

    task automatic t_mode_latch;
        do_reset(0, 0, 8'd255);
        wait_after(5); pal = 1; wide = 1;
        wait_after(100);  chk(status[0], 0, "R4 format not latched mid-frame");
        wait_after(788);  chk(vpend, 0, "R4 width not latched mid-frame");
        wait_after(798);  chk(vpend, 1, "R4 narrow offset kept for frame");
        wait_after(1279); chk(status[0], 0, "R4 format unchanged at frame end");
        wait_after(1280); chk(status[0], 1, "R4 format latched at line 0");
    endtask

    task automatic t_passthrough;
        do_reset(0, 0, 8'd255);
        wait_after(10);
        ffull = 1; fempty = 0; dma = 1; #1;
        chk(status, 16'h0202, "R9 fifo full and dma busy");
        ffull = 0; fempty = 1; dma = 0; #1;
        chk(status, 16'h0100, "R9 fifo empty");
        fempty = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_hint_interval2();
        t_hint_every_line();
        t_vint_ntsc();
        t_vint_pal_wide();
        t_set_wins();
        t_mode_latch();
        t_passthrough();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule